// File: doc/BRIEF.md
# Run-Time Configurable Stack Pointer Unit

This block keeps a stack in a small local word memory. The memory is byte-addressed and holds 32-bit words. The block runs push and pop operations against that memory and owns the stack pointer. A two-bit mode input selects the stack convention at run time. One bit picks whether the stack grows toward lower or higher addresses. The other bit picks whether the pointer marks the most recent entry ("full") or the next free slot ("empty"). The mode decides the order of the two steps in each operation: the pointer update and the memory access.

Each accepted request takes two clock cycles, and `busy_o` is high for both. A push into a stack that already holds its configured number of entries is rejected with a one-cycle overflow pulse. A pop from an empty stack is rejected with a one-cycle underflow pulse. A rejected request changes neither the pointer nor the memory. The pointer is always visible on `sp_o`.

Top module: `stack_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, the mode is 2'b00 (descending, full), `sp_o` equals the top of the region (BASE + 4*DEPTH; 0x110 with the defaults), and `busy_o`, `ovf_o` and `unf_o` are low.
- R2: Mode 2'b00 (descending, full): a push first lowers the pointer by 4 and then stores the data at the new pointer. The empty-stack pointer is BASE + 4*DEPTH.
- R3: Mode 2'b01 (descending, empty): a push stores the data at the current pointer and then lowers the pointer by 4. The empty-stack pointer is BASE + 4*DEPTH - 4.
- R4: Mode 2'b10 (ascending, full): a push first raises the pointer by 4 and then stores the data at the new pointer. The empty-stack pointer is BASE - 4.
- R5: Mode 2'b11 (ascending, empty): a push stores the data at the current pointer and then raises the pointer by 4. The empty-stack pointer is BASE.
- R6: A pop undoes a push in the same mode. In full modes it reads at the pointer and then steps back. In empty modes it steps back and then reads. The popped word appears on `rdata_o`, and pops return data in last-in first-out order.
- R7: An accepted request raises `busy_o` for exactly the two cycles after the accepting edge. Push or pop requests made while `busy_o` is high have no effect.
- R8: A push while DEPTH entries are held raises `ovf_o` for one cycle and leaves the pointer, the entry count and the stored data unchanged.
- R9: A pop while the stack is empty raises `unf_o` for one cycle and leaves the pointer and `rdata_o` unchanged.
- R10: `mode_load_i` takes effect only while the block is idle, the stack is empty and no push or pop is requested. It then loads the new mode and sets the pointer to that mode's empty-stack value. Otherwise it is ignored.
- R11: When push and pop are requested in the same idle cycle, the push is served and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wdata_i | input | DATA_W | Word to push, sampled when the push is accepted |
| mode_load_i | input | 1 | Request to switch the stack convention |
| mode_i | input | 2 | New convention: bit 1 = ascending, bit 0 = empty pointer |
| busy_o | output | 1 | Operation in progress |
| rdata_o | output | DATA_W | Last popped word |
| sp_o | output | ADDR_W | Current stack pointer (byte address) |
| ovf_o | output | 1 | One-cycle pulse for a rejected push |
| unf_o | output | 1 | One-cycle pulse for a rejected pop |

## Verification
The main sequence runs the same push-push-pop-pop pattern in all four modes. The pointer value after every step tells the two growth directions apart. It also tells the two pointer conventions apart, because their empty-stack values and step order differ. The popped words confirm last-in first-out order and that each word came back from the slot it was stored in. Directed patterns then fill the stack to the limit and push once more, drain it and pop once more, try a mode switch with one entry held, issue a request during an operation, and raise push and pop together. Each of these separates accepted requests from rejected ones.

// File: rtl/stk_pkg.sv
// Package: shared encodings for the stack pointer unit.
// Assumes mode bit 1 = ascending growth, mode bit 0 = pointer at next free slot.
package stk_pkg;
    typedef enum logic [1:0] {
        DESC_FULL  = 2'b00,
        DESC_EMPTY = 2'b01,
        ASC_FULL   = 2'b10,
        ASC_EMPTY  = 2'b11
    } stk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PH1  = 2'b01,
        ST_PH2  = 2'b10
    } stk_state_e;
endpackage

// File: rtl/stk_seq.sv
// Module: stk_seq
// Two-phase operation sequencer. It accepts one push or pop while idle, with
// push winning over pop. It then issues a pointer step and a memory access in
// the order given by the pointer convention. Requests that find the stack full
// (push) or empty (pop) are rejected with a one-cycle flag.
// Assumes is_full and is_empty come from registered state.
module stk_seq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              is_full,
    input  logic              is_empty,
    input  logic              empty_conv,
    output logic              idle,
    output logic              busy,
    output logic              start,
    output logic              op_push,
    output logic              step_en,
    output logic              access_en,
    output logic [DATA_W-1:0] wdata_hold,
    output logic              ovf,
    output logic              unf
);
    import stk_pkg::*;

    stk_state_e state;
    logic       step_first;

    // Decode whether a request is accepted in this cycle.
    always_comb begin
        idle  = (state == ST_IDLE);
        busy  = !idle;
        start = idle && ((push_req && !is_full) || (!push_req && pop_req && !is_empty));
    end

    // Order the two phases: full push / empty pop step the pointer first.
    always_comb begin
        step_first = op_push ^ empty_conv;
        step_en    = ((state == ST_PH1) && step_first) || ((state == ST_PH2) && !step_first);
        access_en  = ((state == ST_PH1) && !step_first) || ((state == ST_PH2) && step_first);
    end

    // Advance the phase counter and latch the operation on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_push    <= 1'b0;
            wdata_hold <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_PH1;
                    op_push    <= push_req;
                    wdata_hold <= wdata_in;
                end
                ST_PH1:  state <= ST_PH2;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Produce one-cycle rejection flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= idle && push_req && is_full;
            unf <= idle && !push_req && pop_req && is_empty;
        end
    end

    // R7: an accepted request keeps busy high for exactly two cycles.
    a_r7_two_phase: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy ##1 busy ##1 !busy);

    // R11: a rejected push never starts an operation, even with pop raised.
    a_r11_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && push_req && pop_req) |=> (ovf || op_push));
endmodule

// File: rtl/stk_ptr.sv
// Module: stk_ptr
// Owns the stack pointer, the entry count and the active convention. It steps
// the pointer by one word when the sequencer asks and reloads the
// convention-specific empty value on an accepted mode switch.
// Assumes BASE >= 4 and that the sequencer never steps past the limits.
module stk_ptr #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 256,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ok,
    input  logic [1:0]        mode_in,
    input  logic              step_en,
    input  logic              op_push,
    output logic [ADDR_W-1:0] sp,
    output logic [1:0]        mode,
    output logic              is_full,
    output logic              is_empty
);
    import stk_pkg::*;

    localparam int              CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] LO   = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI   = ADDR_W'(BASE + 4 * DEPTH);
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    logic [CNT_W-1:0] cnt;
    logic             step_up;

    // Empty-stack pointer value for a given convention.
    function automatic logic [ADDR_W-1:0] empty_sp(input logic [1:0] m);
        case (stk_mode_e'(m))
            DESC_FULL:  return HI;
            DESC_EMPTY: return HI - WORD;
            ASC_FULL:   return LO - WORD;
            default:    return LO;
        endcase
    endfunction

    // Derive occupancy and step direction.
    always_comb begin
        is_full  = (cnt == CNT_W'(DEPTH));
        is_empty = (cnt == '0);
        step_up  = !(op_push ^ mode[1]);
    end

    // Update pointer, count and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= DESC_FULL;
            sp   <= empty_sp(DESC_FULL);
            cnt  <= '0;
        end else if (load_ok) begin
            mode <= mode_in;
            sp   <= empty_sp(mode_in);
        end else if (step_en) begin
            sp  <= step_up ? sp + WORD : sp - WORD;
            cnt <= op_push ? cnt + 1'b1 : cnt - 1'b1;
        end
    end

    // R8: the entry count never exceeds the configured depth.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R10: the convention stays fixed while entries are held.
    a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !is_empty |=> $stable(mode));

    // R6: the pointer stays inside the region plus one guard word.
    a_r6_sp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sp >= LO - WORD) && (sp <= HI));
endmodule

// File: rtl/stk_mem.sv
// Module: stk_mem
// Local word store for the stack. Writes are synchronous. The read result is
// registered on the read strobe and held until the next read.
// Assumes the index is in range whenever a strobe is high.
module stk_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    // Store a pushed word.
    always_ff @(posedge clk) begin
        if (we) store[idx] <= wdata;
    end

    // Capture a popped word.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[idx];
    end

    // R6: one memory access per phase, never a read and a write together.
    a_r6_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/stack_ptr_unit.sv
// Module: stack_ptr_unit
// Top of the configurable stack pointer unit. It connects the sequencer, the
// pointer register and the local word store, and maps the byte pointer to a
// word index inside the region [BASE, BASE + 4*DEPTH).
// Assumes DEPTH >= 2 and a region that fits in ADDR_W bits.
module stack_ptr_unit #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BASE   = 256,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mode_load_i,
    input  logic [1:0]        mode_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              idle, start, op_push, step_en, access_en;
    logic              is_full, is_empty, load_ok;
    logic [1:0]        mode;
    logic [DATA_W-1:0] wdata_hold;
    logic [ADDR_W-1:0] offs;
    logic [IDX_W-1:0]  idx;

    // Gate a mode switch and map the pointer to a word index.
    always_comb begin
        load_ok = idle && mode_load_i && !push_i && !pop_i && is_empty;
        offs    = sp_o - ADDR_W'(BASE);
        idx     = offs[IDX_W+1:2];
    end

    stk_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .push_req(push_i), .pop_req(pop_i),
        .wdata_in(wdata_i), .is_full(is_full), .is_empty(is_empty),
        .empty_conv(mode[0]), .idle(idle), .busy(busy_o), .start(start),
        .op_push(op_push), .step_en(step_en), .access_en(access_en),
        .wdata_hold(wdata_hold), .ovf(ovf_o), .unf(unf_o)
    );

    stk_ptr #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_ok(load_ok), .mode_in(mode_i),
        .step_en(step_en), .op_push(op_push), .sp(sp_o), .mode(mode),
        .is_full(is_full), .is_empty(is_empty)
    );

    stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(access_en && op_push),
        .re(access_en && !op_push), .idx(idx), .wdata(wdata_hold),
        .rdata(rdata_o)
    );

    // R8: a rejected push leaves the pointer alone and starts nothing.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($stable(sp_o) && !busy_o));

    // R9: a rejected pop leaves the pointer and read data alone.
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> ($stable(sp_o) && $stable(rdata_o) && !busy_o));

    // R7: the store is only written during an operation.
    a_r7_write_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && op_push) |-> busy_o);
endmodule

// File: tb/sim_stack_ptr_unit.sv
module sim_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0, mode_load_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic        busy_o, ovf_o, unf_o;
    logic [31:0] rdata_o;
    logic [11:0] sp_o;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    stack_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .wdata_i(wdata_i), .mode_load_i(mode_load_i), .mode_i(mode_i),
        .busy_o(busy_o), .rdata_o(rdata_o), .sp_o(sp_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // op: 0 push, 1 pop, 2 mode switch
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] arg;
        logic [11:0] sp;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VECS [20] = '{
        '{2'd0, 32'hA1, 12'h10C, 32'h0},  // R2 descending full
        '{2'd0, 32'hA2, 12'h108, 32'h0},
        '{2'd1, 32'h0,  12'h10C, 32'hA2}, // R6
        '{2'd1, 32'h0,  12'h110, 32'hA1},
        '{2'd2, 32'h1,  12'h10C, 32'h0},  // R10 to descending empty
        '{2'd0, 32'hB1, 12'h108, 32'h0},  // R3
        '{2'd0, 32'hB2, 12'h104, 32'h0},
        '{2'd1, 32'h0,  12'h108, 32'hB2},
        '{2'd1, 32'h0,  12'h10C, 32'hB1},
        '{2'd2, 32'h2,  12'h0FC, 32'h0},  // to ascending full
        '{2'd0, 32'hC1, 12'h100, 32'h0},  // R4
        '{2'd0, 32'hC2, 12'h104, 32'h0},
        '{2'd1, 32'h0,  12'h100, 32'hC2},
        '{2'd1, 32'h0,  12'h0FC, 32'hC1},
        '{2'd2, 32'h3,  12'h100, 32'h0},  // to ascending empty
        '{2'd0, 32'hD1, 12'h104, 32'h0},  // R5
        '{2'd0, 32'hD2, 12'h108, 32'h0},
        '{2'd1, 32'h0,  12'h104, 32'hD2},
        '{2'd1, 32'h0,  12'h100, 32'hD1},
        '{2'd0, 32'hD3, 12'h104, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; wait until its effect is visible.
    task automatic do_op(input logic [1:0] op, input logic [31:0] arg, input logic both);
        @(negedge clk);
        push_i      = (op == 2'd0) || both;
        pop_i       = (op == 2'd1) || both;
        mode_load_i = (op == 2'd2);
        wdata_i     = arg;
        mode_i      = arg[1:0];
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; mode_load_i = 1'b0;
        if (op != 2'd2) repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sp", 32'(sp_o), 32'h110);
        chk("R1 busy", 32'(busy_o), 32'h0);
        chk("R1 flags", {30'h0, ovf_o, unf_o}, 32'h0);

        for (int i = 0; i < 20; i++) begin
            do_op(VECS[i].op, VECS[i].arg, 1'b0);
            chk("R2-R6 vector sp", 32'(sp_o), 32'(VECS[i].sp));
            if (VECS[i].op == 2'd1) chk("R6 vector data", rdata_o, VECS[i].rd);
        end
        do_op(2'd1, 0, 1'b0);  // back to empty, ascending empty, sp 0x100

        // R7: busy for two cycles, a request during busy is ignored
        @(negedge clk); push_i = 1'b1; wdata_i = 32'h11;
        @(negedge clk); push_i = 1'b1; wdata_i = 32'h22;
        chk("R7 busy c1", 32'(busy_o), 32'h1);
        @(negedge clk); push_i = 1'b0;
        chk("R7 busy c2", 32'(busy_o), 32'h1);
        @(negedge clk);
        chk("R7 busy end", 32'(busy_o), 32'h0);
        chk("R7 sp one step", 32'(sp_o), 32'h104);
        do_op(2'd1, 0, 1'b0);
        chk("R7 ignored push data", rdata_o, 32'h11);

        // R8: fill then push once more
        for (int k = 0; k < 4; k++) do_op(2'd0, 32'hE0 + 32'(k), 1'b0);
        chk("R8 full sp", 32'(sp_o), 32'h110);
        @(negedge clk); push_i = 1'b1; wdata_i = 32'hEE;
        @(negedge clk); push_i = 1'b0;
        chk("R8 ovf pulse", 32'(ovf_o), 32'h1);
        chk("R8 sp held", 32'(sp_o), 32'h110);
        chk("R8 not busy", 32'(busy_o), 32'h0);
        @(negedge clk);
        chk("R8 ovf cleared", 32'(ovf_o), 32'h0);
        do_op(2'd1, 0, 1'b0);
        chk("R8 top intact", rdata_o, 32'hE3);
        for (int k = 0; k < 3; k++) do_op(2'd1, 0, 1'b0);
        chk("R8 drained sp", 32'(sp_o), 32'h100);

        // R9: pop from empty
        @(negedge clk); pop_i = 1'b1;
        @(negedge clk); pop_i = 1'b0;
        chk("R9 unf pulse", 32'(unf_o), 32'h1);
        chk("R9 sp held", 32'(sp_o), 32'h100);
        chk("R9 data held", rdata_o, 32'hE0);

        // R10: switch refused with an entry held
        do_op(2'd0, 32'h77, 1'b0);
        do_op(2'd2, 32'h0, 1'b0);
        chk("R10 refused", 32'(sp_o), 32'h104);
        do_op(2'd1, 0, 1'b0);
        chk("R10 mode kept", rdata_o, 32'h77);
        do_op(2'd2, 32'h0, 1'b0);
        chk("R10 accepted", 32'(sp_o), 32'h110);

        // R11: push and pop together
        do_op(2'd0, 32'h55, 1'b1);
        chk("R11 push served", 32'(sp_o), 32'h10C);
        do_op(2'd1, 0, 1'b0);
        chk("R11 data", rdata_o, 32'h55);
        chk("R11 sp back", 32'(sp_o), 32'h110);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule